// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block holds an eight-stage register that can take a whole byte at once and then hand it out one bit at a time. It lives entirely inside one fast system clock. The slow shift clock, its active-low enable and the active-low load strobe arrive as ordinary pins. The block samples them, passes them through synchronizers and looks for edges in the system clock domain.

While the load strobe is asserted, every stage tracks its parallel data input. No shift can happen during that time. Once the strobe is released, the stages move one place toward the last stage on each shift event, and the serial input fills stage 0.

A shift event is a rising edge of the OR of the shift clock and the enable. The two pins are therefore interchangeable: one can be held low while the other produces the edge. The last stage drives a true output and a complementary output.

Top module: `psr_shift_reg`

## Requirements
- R1: A synchronous active-high `rst` clears all stages to zero, so `q_o` reads 0 and `q_n_o` reads 1 after reset.
- R2: While `load_n_i` is low, stage n follows `par_i[n]` (bit 7 is the last stage), whatever `sclk_i`, `sen_n_i` and `ser_i` do, and a changed `par_i` is picked up while the strobe stays low.
- R3: With `sen_n_i` low, a low-to-high edge on `sclk_i` shifts once: `ser_i` enters stage 0, stage k takes the old stage k-1, and `q_o` shows stage 7. A byte therefore leaves with bit 7 first.
- R4: With `sclk_i` low, a low-to-high edge on `sen_n_i` shifts exactly like a clock edge.
- R5: With the load strobe high, no stage changes while either `sclk_i` or `sen_n_i` is held high, however often the other pin toggles.
- R6: `q_n_o` is always the inverse of `q_o`.
- R7: The bit shifted in is the value `ser_i` had when the edge arrived; a change of `ser_i` shortly after the edge does not alter it.
- R8: Releasing the load strobe never causes a shift, even when the clock rises at the same instant, and clock edges during load have no effect.
- R9: A clock held high for many system cycles produces a single shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Shift clock pin, rising edge active |
| sen_n_i | input | 1 | Shift enable pin, active low |
| load_n_i | input | 1 | Parallel load strobe, active low |
| ser_i | input | 1 | Serial data in |
| par_i | input | WIDTH | Parallel data in |
| q_o | output | 1 | Last stage, true |
| q_n_o | output | 1 | Last stage, inverted |

## Verification
The bench targets the instant the load strobe is released together with a rising clock. A design without the edge re-initialisation would shift once there and lose the top bit of the loaded byte.

It also holds the clock high for a long time. A level-sensitive design would then fill the register with copies of the serial bit.

It changes the serial input one system cycle after the clock edge. A design whose serial path is not delayed to match the synchronizers would capture the new value instead of the old one.

Finally, it toggles one control pin while the other is held high, and it drives edges on the enable pin with the clock low. These catch a design that ignores the OR gating or treats only one pin as a clock.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_SHIFT = 2'd2
  } psr_mode_e;

  localparam int unsigned CTRL_W = 4;
  // Packing of the sampled pins: {ser, load_n, sen_n, sclk}
  localparam int unsigned IDX_SCLK  = 0;
  localparam int unsigned IDX_SEN_N = 1;
  localparam int unsigned IDX_LOAD_N = 2;
  localparam int unsigned IDX_SER   = 3;
  localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b0110;

  function automatic psr_mode_e pick_mode(input logic load_n, input logic shift_evt);
    if (!load_n)        return MODE_LOAD;
    else if (shift_evt) return MODE_SHIFT;
    else                return MODE_HOLD;
  endfunction
endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/psr_edge.sv
module psr_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic sen_n_s,
  input  logic load_n_s,
  output logic gate_now,
  output logic release_evt,
  output logic shift_evt
);
  logic gate_prev;
  logic load_n_prev;

  assign gate_now    = sclk_s | sen_n_s;
  assign release_evt = load_n_s & ~load_n_prev;
  assign shift_evt   = load_n_s & ~release_evt & gate_now & ~gate_prev;

  // The previous gate value always follows the current one, so on the
  // release cycle it is re-initialised and no stale edge survives.
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_prev   <= 1'b1;
      load_n_prev <= 1'b1;
    end else begin
      gate_prev   <= gate_now;
      load_n_prev <= load_n_s;
    end
  end
endmodule

// File: rtl/psr_stages.sv
module psr_stages
  import psr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  psr_mode_e        mode,
  input  logic             ser_bit,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] stages
);
  function automatic logic [WIDTH-1:0] shift_one(input logic [WIDTH-1:0] cur,
                                                input logic in_bit);
    return {cur[WIDTH-2:0], in_bit};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      stages <= '0;
    end else begin
      unique case (mode)
        MODE_LOAD:  stages <= par_i;
        MODE_SHIFT: stages <= shift_one(stages, ser_bit);
        default:    stages <= stages;
      endcase
    end
  end
endmodule

// File: rtl/psr_shift_reg.sv
module psr_shift_reg
  import psr_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             sen_n_i,
  input  logic             load_n_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             q_o,
  output logic             q_n_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic [CTRL_W-1:0] pins_raw;
  logic [CTRL_W-1:0] pins_s;
  logic              load_n_s;
  logic              ser_d;
  logic              gate_now;
  logic              release_evt;
  logic              shift_evt;
  psr_mode_e         mode;
  logic [WIDTH-1:0]  stages;

  assign pins_raw[IDX_SCLK]   = sclk_i;
  assign pins_raw[IDX_SEN_N]  = sen_n_i;
  assign pins_raw[IDX_LOAD_N] = load_n_i;
  assign pins_raw[IDX_SER]    = ser_i;

  // Serial data rides in the same synchronizer so it stays aligned with the edge.
  psr_sync #(
    .WIDTH  (CTRL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTRL_IDLE)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i(pins_raw),
    .q_o(pins_s)
  );

  assign load_n_s = pins_s[IDX_LOAD_N];
  assign ser_d    = pins_s[IDX_SER];

  psr_edge u_edge (
    .clk        (clk),
    .rst        (rst),
    .sclk_s     (pins_s[IDX_SCLK]),
    .sen_n_s    (pins_s[IDX_SEN_N]),
    .load_n_s   (load_n_s),
    .gate_now   (gate_now),
    .release_evt(release_evt),
    .shift_evt  (shift_evt)
  );

  assign mode = pick_mode(load_n_s, shift_evt);

  psr_stages #(.WIDTH(WIDTH)) u_stages (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .ser_bit(ser_d),
    .par_i  (par_i),
    .stages (stages)
  );

  assign q_o   = stages[LAST];
  assign q_n_o = ~stages[LAST];
endmodule

// File: rtl/psr_shift_reg_chk.sv
module psr_shift_reg_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             load_n_s,
  input logic             gate_now,
  input logic             shift_evt,
  input logic             ser_d,
  input logic [WIDTH-1:0] par_i,
  input logic [WIDTH-1:0] stages,
  input logic             q_o,
  input logic             q_n_o
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> stages == '0);

  p_load_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !load_n_s |=> stages == $past(par_i));

  p_shift_order_r3: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> stages == {$past(stages[WIDTH-2:0]), $past(ser_d)});

  p_out_last_r3: assert property (@(posedge clk) disable iff (rst)
    q_o == stages[WIDTH-1]);

  p_hold_high_r5: assert property (@(posedge clk) disable iff (rst)
    (load_n_s && gate_now && $past(gate_now)) |=> $stable(stages));

  p_inverse_r6: assert property (@(posedge clk) disable iff (rst)
    q_n_o == ~q_o);

  p_no_release_shift_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(load_n_s) |=> $stable(stages));

  p_single_edge_r9: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> !shift_evt);
endmodule

bind psr_shift_reg psr_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load_n_s (load_n_s),
  .gate_now (gate_now),
  .shift_evt(shift_evt),
  .ser_d    (ser_d),
  .par_i    (par_i),
  .stages   (stages),
  .q_o      (q_o),
  .q_n_o    (q_n_o)
);

// File: tb/psr_shift_reg_tb_top.sv
module psr_shift_reg_tb_top;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sen_n = 1'b0, load_n = 1'b1, ser = 1'b0;
  logic [W-1:0] par = '0;
  logic q, q_n;
  logic [W-1:0] exp_q = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  psr_shift_reg #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sen_n_i(sen_n), .load_n_i(load_n),
    .ser_i(ser), .par_i(par), .q_o(q), .q_n_o(q_n)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic check_out(input string req);
    check(q == exp_q[W-1], req, int'(q), int'(exp_q[W-1]));
    check(q_n == ~q, "R6", int'(q_n), int'(~q));
  endtask

  // Clock edge with enable low; model shifts.
  task automatic clk_shift(input logic b);
    ser = b; sen_n = 1'b0; tick(4);
    sclk = 1'b1; tick(4);
    sclk = 1'b0; tick(4);
    exp_q = {exp_q[W-2:0], b};
  endtask

  task automatic do_load(input logic [W-1:0] v);
    par = v; load_n = 1'b0; tick(4);
    load_n = 1'b1; tick(4);
    exp_q = v;
  endtask

  task automatic read_byte(output logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) begin
      v[i] = q;
      clk_shift(1'b0);
    end
  endtask

  task automatic t_reset;
    check(q == 1'b0, "R1", int'(q), 0);
    check(q_n == 1'b1, "R1", int'(q_n), 1);
  endtask

  task automatic t_load_and_release;
    logic [W-1:0] got;
    par = 8'hA5; load_n = 1'b0; tick(4);
    check(q == 1'b1, "R2", int'(q), 1);
    sclk = 1'b1; ser = 1'b1; tick(4);
    sclk = 1'b0; tick(4);
    par = 8'h3C; tick(4);
    check(q == 1'b0, "R2", int'(q), 0);
    // Release and raise clock together: must not shift (R8).
    load_n = 1'b1; sclk = 1'b1; tick(6);
    sclk = 1'b0; tick(4);
    exp_q = 8'h3C;
    check_out("R8");
    read_byte(got);
    check(got == 8'h3C, "R8", int'(got), 8'h3C);
  endtask

  task automatic t_clk_shift;
    logic [W-1:0] got;
    logic [W-1:0] pat = 8'hB2;
    do_load(8'h00);
    for (int i = W - 1; i >= 0; i--) begin
      clk_shift(pat[i]);
      check_out("R3");
    end
    read_byte(got);
    check(got == 8'hB2, "R3", int'(got), 8'hB2);
  endtask

  task automatic t_en_shift;
    logic [W-1:0] got;
    logic [W-1:0] pat = 8'h6D;
    do_load(8'hFF);
    sclk = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      sen_n = 1'b0; ser = pat[i]; tick(4);
      sen_n = 1'b1; tick(4);
      exp_q = {exp_q[W-2:0], pat[i]};
    end
    sen_n = 1'b0; tick(4);
    check_out("R4");
    read_byte(got);
    check(got == 8'h6D, "R4", int'(got), 8'h6D);
  endtask

  task automatic t_hold;
    logic [W-1:0] got;
    do_load(8'h81);
    ser = 1'b1; sen_n = 1'b0; tick(4);
    sclk = 1'b1; tick(4);
    exp_q = {exp_q[W-2:0], 1'b1};
    for (int i = 0; i < 4; i++) begin
      sen_n = 1'b1; tick(3);
      sen_n = 1'b0; tick(3);
    end
    sen_n = 1'b1; tick(3);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0; tick(3);
      sclk = 1'b1; tick(3);
    end
    sclk = 1'b0; tick(3);
    sen_n = 1'b0; tick(4);
    check_out("R5");
    read_byte(got);
    check(got == 8'h03, "R5", int'(got), 8'h03);
  endtask

  task automatic t_setup;
    logic [W-1:0] got;
    do_load(8'h00);
    ser = 1'b1; tick(4);
    sclk = 1'b1; tick(1);
    ser = 1'b0; tick(6);
    sclk = 1'b0; tick(4);
    exp_q = 8'h01;
    read_byte(got);
    check(got == 8'h01, "R7", int'(got), 8'h01);
  endtask

  task automatic t_long_high;
    logic [W-1:0] got;
    do_load(8'h00);
    ser = 1'b1; tick(4);
    sclk = 1'b1; tick(40);
    sclk = 1'b0; tick(4);
    read_byte(got);
    check(got == 8'h01, "R9", int'(got), 8'h01);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_load_and_release();
    t_clk_shift();
    t_en_shift();
    t_hold();
    t_setup();
    t_long_high();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end
endmodule